// File: doc/BRIEF.md
# Configuration ROM image validator

This block checks a configuration ROM image that arrives as a byte stream, one byte per accepted beat, with a marker on the final byte. A fixed 22-byte header comes first. Byte 0 is an 8-bit checksum of the 64-bit unique ID in bytes 1 to 8. Bytes 9 to 12 hold a 32-bit checksum of the data region. Byte 13 is a revision. A 10-bit length in bytes 14 to 15 sets the image size. Vendor and model IDs follow. The block reports these fields and checksum results. It then walks the chain of variable-length entries that begins at byte 22 and emits one record per entry, with the entry's index, disabled bit and type. It raises sticky error flags for structural faults.

The input is valid/ready. A byte transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high unless a record is waiting and `rec_ready` is low. The path from `rec_ready` to `in_ready` is combinational. The record output is valid/ready as well. A record stays valid and unchanged until `rec_ready` takes it. Status outputs are plain levels. They are meaningful while `done` is high, and they clear on the first byte of the next image.

Top module: `cfgrom_validator`

## Requirements
- R1: `in_ready` is low in any cycle where `rec_valid` is high and `rec_ready` is low. A pending record holds `rec_index`, `rec_disabled` and `rec_port` stable until it is accepted.
- R2: `uid` is bytes 1 to 8 read little-endian. `vendor_id` is bytes 16 to 17 and `model_id` is bytes 18 to 19, both little-endian.
- R3: `id_ok` is 1 when byte 0 equals an 8-bit checksum of bytes 1 to 8. That checksum uses polynomial 0x07, starts at 0xFF, XORs each byte in and then shifts 8 times MSB first, with no final inversion. A mismatch is fatal: no records are emitted.
- R4: `data_ok` is 1 when bytes 9 to 12, read little-endian, equal the inverted result of a reflected 32-bit checksum with polynomial 0x82F63B78 and start value 0xFFFFFFFF. The checksum runs over the data_len bytes that begin at byte 13. A mismatch only clears `data_ok`, and the entry walk continues.
- R5: The image size is data_len + 13, where data_len is the low 10 bits of the little-endian word at bytes 14 to 15. The upper 6 bits are ignored. A size below 22 sets `size_err`, and no records are emitted.
- R6: `rev_warn` is 1 when byte 13 is greater than 2.
- R7: Entries start at byte 22. Byte 0 of an entry is its length, which includes the 2-byte entry header. Byte 1 carries the index in bits 5:0, the disabled flag in bit 6 and the type in bit 7 (1 = port, 0 = generic). Each accepted entry produces one record, in stream order, on the cycle after its byte 1 is accepted.
- R8: `overrun_err` is set, and the walk stops with no further records, in three cases. The first is an entry length byte that is the image's last byte. The second is a length of 0 or 1. The third is a length that would run past the image's end.
- R9: A port entry with index at most MAX_PORT and length other than 8 sets `port_len_err`. That entry and all later entries produce no record. A port entry with index above MAX_PORT produces no record and no error, and the walk goes on.
- R10: If `in_last` arrives before the image size is reached, `trunc_err` is set and `data_ok` is 0.
- R11: Bytes after the image size, up to `in_last`, produce no records and change no result.
- R12: `done` rises on the cycle after the beat that carries `in_last`. The first beat of the next image clears `done` and all results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Final byte of the stream |
| rec_valid | output | 1 | Entry record valid |
| rec_ready | input | 1 | Sink accepts the record |
| rec_index | output | 6 | Entry index |
| rec_disabled | output | 1 | Entry disabled flag |
| rec_port | output | 1 | Entry type, 1 = port |
| done | output | 1 | Image finished, results valid |
| id_ok | output | 1 | ID checksum matched |
| data_ok | output | 1 | Data checksum matched |
| size_err | output | 1 | Image size below header size |
| trunc_err | output | 1 | Stream ended early |
| overrun_err | output | 1 | Entry chain overran the image |
| port_len_err | output | 1 | Port entry of wrong length |
| rev_warn | output | 1 | Revision above 2 |
| uid | output | 64 | Unique ID |
| vendor_id | output | 16 | Vendor ID |
| model_id | output | 16 | Model ID |

## Verification
The bench builds the block with MAX_PORT = 3 and keeps the 10-bit length field. A small port count puts indices on both sides of the skip threshold within a few bytes. It covers an index equal to the limit, which is recorded, and an index above it, which is skipped. Garbage in the upper length bits exercises the 10-bit mask. A record sink that toggles its ready each cycle makes the entry records stall the input. Short images bring each overrun cause, truncation, trailing bytes and a one-byte image within a few dozen cycles.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int HDR_BYTES  = 22;
  localparam int DATA_START = 13;
  localparam int PORT_LEN   = 8;

  typedef struct packed {
    logic       is_port;
    logic       disabled;
    logic [5:0] idx;
  } ent_hdr_t;
endpackage

// File: rtl/cfgrom_crc.sv
module cfgrom_crc #(
  parameter int              WIDTH   = 8,
  parameter logic [WIDTH-1:0] POLY   = 'h07,
  parameter logic [WIDTH-1:0] INIT   = '1,
  parameter bit              REFLECT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic [7:0]       data,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] base;
  logic [WIDTH-1:0] c;

  assign base = start ? INIT : state;

  generate
    if (REFLECT) begin : g_lsb
      always_comb begin
        c = base ^ WIDTH'(data);
        for (int i = 0; i < 8; i++)
          c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
      end
    end else begin : g_msb
      always_comb begin
        c = base ^ (WIDTH'(data) << (WIDTH - 8));
        for (int i = 0; i < 8; i++)
          c = c[WIDTH-1] ? ((c << 1) ^ POLY) : (c << 1);
      end
    end
  endgenerate

  assign nxt = c;

  always_ff @(posedge clk) begin
    if (rst) state <= INIT;
    else if (en) state <= c;
  end
endmodule

// File: rtl/cfgrom_walker.sv
module cfgrom_walker
  import cfgrom_pkg::*;
#(
  parameter int PW       = 11,
  parameter int MAX_PORT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat,
  input  logic          first,
  input  logic          allow,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] tot,
  input  logic [7:0]    data,
  output logic          rec_fire,
  output ent_hdr_t      rec_hdr,
  output logic          overrun,
  output logic          plen_err
);
  logic [PW-1:0] nxt_ent;
  logic [7:0]    cur_len;
  logic          in_hdr, stopped;
  logic          live, len_beat, hdr_beat, ovr, bad_len, skip;
  ent_hdr_t      h;

  assign h        = ent_hdr_t'(data);
  assign live     = beat && allow && !stopped && !first &&
                    (pos >= PW'(HDR_BYTES)) && (pos < tot);
  assign len_beat = live && !in_hdr && (pos == nxt_ent);
  assign hdr_beat = live && in_hdr;

  assign ovr = (({1'b0, pos} + (PW+1)'(1)) == {1'b0, tot}) ||
               (data < 8'd2) ||
               (({1'b0, pos} + (PW+1)'(data)) > {1'b0, tot});

  assign skip     = h.is_port && (int'(h.idx) > MAX_PORT);
  assign bad_len  = h.is_port && !skip && (cur_len != 8'(PORT_LEN));
  assign rec_fire = hdr_beat && !bad_len && !skip;
  assign rec_hdr  = h;

  always_ff @(posedge clk) begin
    if (rst || (beat && first)) begin
      nxt_ent  <= PW'(HDR_BYTES);
      cur_len  <= '0;
      in_hdr   <= 1'b0;
      stopped  <= 1'b0;
      overrun  <= 1'b0;
      plen_err <= 1'b0;
    end else begin
      if (hdr_beat) begin
        in_hdr <= 1'b0;
        if (bad_len) begin
          plen_err <= 1'b1;
          stopped  <= 1'b1;
        end
      end
      if (len_beat) begin
        if (ovr) begin
          overrun <= 1'b1;
          stopped <= 1'b1;
        end else begin
          nxt_ent <= pos + PW'(data);
          cur_len <= data;
          in_hdr  <= 1'b1;
        end
      end
    end
  end

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (overrun || plen_err) |-> !rec_fire);

  assert_err_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overrun, plen_err}));
endmodule

// File: rtl/cfgrom_validator.sv
module cfgrom_validator
  import cfgrom_pkg::*;
#(
  parameter int LEN_BITS = 10,
  parameter int MAX_PORT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [5:0]  rec_index,
  output logic        rec_disabled,
  output logic        rec_port,
  output logic        done,
  output logic        id_ok,
  output logic        data_ok,
  output logic        size_err,
  output logic        trunc_err,
  output logic        overrun_err,
  output logic        port_len_err,
  output logic        rev_warn,
  output logic [63:0] uid,
  output logic [15:0] vendor_id,
  output logic [15:0] model_id
);
  localparam int PW = LEN_BITS + 1;

  logic [PW-1:0] pos, total, tot_c;
  logic [7:0]    len_lo, ref8, rev;
  logic [31:0]   ref32;
  logic [15:0]   word;
  logic [7:0]    c8;
  logic [31:0]   c32;
  logic          beat, first, c8_en, c32_en;
  logic          rec_fire;
  ent_hdr_t      rec_hdr;
  logic [2:0]    ub;
  logic [1:0]    rb;

  assign in_ready = !rec_valid || rec_ready;
  assign beat     = in_valid && in_ready;
  assign first    = (pos == '0);
  assign word     = {in_data, len_lo};
  assign tot_c    = (pos == PW'(15)) ?
                    (PW'(word[LEN_BITS-1:0]) + PW'(DATA_START)) : total;
  assign ub       = pos[2:0] - 3'd1;
  assign rb       = pos[1:0] - 2'd1;
  assign rev_warn = (rev > 8'd2);

  assign c8_en  = beat && (pos >= PW'(1)) && (pos <= PW'(8));
  assign c32_en = beat && (pos >= PW'(DATA_START)) && (pos < tot_c);

  cfgrom_crc #(.WIDTH(8), .POLY(8'h07), .INIT(8'hFF), .REFLECT(1'b0)) u_crc8 (
    .clk(clk), .rst(rst), .en(c8_en), .start(pos == PW'(1)),
    .data(in_data), .nxt(c8));

  cfgrom_crc #(.WIDTH(32), .POLY(32'h82F63B78), .INIT(32'hFFFFFFFF),
               .REFLECT(1'b1)) u_crc32 (
    .clk(clk), .rst(rst), .en(c32_en), .start(pos == PW'(DATA_START)),
    .data(in_data), .nxt(c32));

  cfgrom_walker #(.PW(PW), .MAX_PORT(MAX_PORT)) u_walk (
    .clk(clk), .rst(rst), .beat(beat), .first(first), .allow(id_ok),
    .pos(pos), .tot(tot_c), .data(in_data), .rec_fire(rec_fire),
    .rec_hdr(rec_hdr), .overrun(overrun_err), .plen_err(port_len_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0; total <= '1; len_lo <= '0; ref8 <= '0; ref32 <= '0;
      rev <= '0; uid <= '0; vendor_id <= '0; model_id <= '0;
      done <= 1'b0; id_ok <= 1'b0; data_ok <= 1'b0;
      size_err <= 1'b0; trunc_err <= 1'b0;
    end else if (beat) begin
      if (first) begin
        total <= '1; ref32 <= '0; rev <= '0; uid <= '0;
        vendor_id <= '0; model_id <= '0; done <= 1'b0; id_ok <= 1'b0;
        data_ok <= 1'b0; size_err <= 1'b0; trunc_err <= 1'b0;
        ref8 <= in_data;
      end
      if (pos >= PW'(1) && pos <= PW'(8)) uid[{ub, 3'b000} +: 8] <= in_data;
      if (pos == PW'(8)) id_ok <= (c8 == ref8);
      if (pos >= PW'(9) && pos <= PW'(12)) ref32[{rb, 3'b000} +: 8] <= in_data;
      if (pos == PW'(13)) rev <= in_data;
      if (pos == PW'(14)) len_lo <= in_data;
      if (pos == PW'(15)) begin
        total    <= tot_c;
        size_err <= (tot_c < PW'(HDR_BYTES));
      end
      if (pos == PW'(16)) vendor_id[7:0]  <= in_data;
      if (pos == PW'(17)) vendor_id[15:8] <= in_data;
      if (pos == PW'(18)) model_id[7:0]   <= in_data;
      if (pos == PW'(19)) model_id[15:8]  <= in_data;
      if (pos >= PW'(DATA_START) &&
          (({1'b0, pos} + (PW+1)'(1)) == {1'b0, tot_c}))
        data_ok <= (~c32 == ref32);
      if (in_last) begin
        done      <= 1'b1;
        trunc_err <= (pos < PW'(15)) ||
                     (({1'b0, pos} + (PW+1)'(1)) < {1'b0, tot_c});
        pos       <= '0;
      end else if (pos != '1) begin
        pos <= pos + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0; rec_index <= '0; rec_disabled <= 1'b0; rec_port <= 1'b0;
    end else if (rec_fire) begin
      rec_valid    <= 1'b1;
      rec_index    <= rec_hdr.idx;
      rec_disabled <= rec_hdr.disabled;
      rec_port     <= rec_hdr.is_port;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  assert_rec_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid &&
      $stable({rec_index, rec_disabled, rec_port})));

  assert_trunc_nodata_R10: assert property (@(posedge clk) disable iff (rst)
    (done && trunc_err) |-> !data_ok);

  assert_done_rise_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(in_valid && in_ready && in_last));
endmodule

// File: tb/sim_cfgrom_validator.sv
module sim_cfgrom_validator;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, rec_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, rec_valid, rec_disabled, rec_port, done, id_ok, data_ok;
  logic size_err, trunc_err, overrun_err, port_len_err, rev_warn;
  logic [5:0] rec_index;
  logic [63:0] uid;
  logic [15:0] vendor_id, model_id;

  int n_tests = 0, n_fail = 0, viol = 0, rec_cnt = 0, wp = 0;
  bit stall_mode = 1'b0, finished = 1'b0;
  logic [7:0] img [0:255];
  logic [7:0] rec_log [0:31];
  localparam logic [63:0] UID = 64'h0123_4567_89AB_CDEF;

  always #(CLK_NS/2) clk = ~clk;

  cfgrom_validator #(.LEN_BITS(10), .MAX_PORT(3)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_index(rec_index), .rec_disabled(rec_disabled),
    .rec_port(rec_port), .done(done), .id_ok(id_ok), .data_ok(data_ok),
    .size_err(size_err), .trunc_err(trunc_err), .overrun_err(overrun_err),
    .port_len_err(port_len_err), .rev_warn(rev_warn), .uid(uid),
    .vendor_id(vendor_id), .model_id(model_id));

  always begin
    @(negedge clk);
    rec_ready = stall_mode ? ~rec_ready : 1'b1;
    #1;
    if (rec_valid && !rec_ready && in_ready) viol++;
    if (rec_valid && rec_ready && rec_cnt < 32) begin
      rec_log[rec_cnt] = {rec_port, rec_disabled, rec_index};
      rec_cnt++;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] b_crc8(input int from, input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c ^= img[from+i];
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] b_crc32(input int from, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, img[from+i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic begin_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    wp = 22;
  endtask

  task automatic ent(input int len, input logic [7:0] hb);
    img[wp] = 8'(len);
    img[wp+1] = hb;
    for (int k = 2; k < len; k++) img[wp+k] = 8'(8'hA0 + k);
    wp += len;
  endtask

  task automatic finish_img(input int dl, input logic [7:0] rev);
    logic [31:0] c;
    for (int i = 0; i < 8; i++) img[1+i] = UID[8*i +: 8];
    img[13] = rev;
    img[14] = 8'(dl);
    img[15] = {6'b110100, 2'(dl >> 8)};
    img[16] = 8'h5C; img[17] = 8'h3A; img[18] = 8'h17; img[19] = 8'hB2;
    img[20] = 8'h11; img[21] = 8'h22;
    img[0] = b_crc8(1, 8);
    c = b_crc32(13, dl);
    for (int i = 0; i < 4; i++) img[9+i] = c[8*i +: 8];
  endtask

  task automatic send(input int cnt);
    rec_cnt = 0;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = img[i]; in_last = (i == cnt - 1);
      #2;
      while (!in_ready) begin @(negedge clk); #2; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #3;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #3;
  endtask

  task automatic chk_recs(input string tag, input int n, input logic [31:0] exp);
    check({tag, " record count"}, 64'(rec_cnt), 64'(n));
    for (int i = 0; i < n && i < rec_cnt; i++)
      check({tag, " record"}, 64'(rec_log[i]), 64'(exp[8*i +: 8]));
  endtask

  task automatic build_good(input logic [7:0] rev);
    begin_img();
    ent(4, 8'h01); ent(8, 8'h82); ent(8, 8'hC3); ent(2, 8'h05);
    finish_img(wp - 13, rev);
  endtask

  task automatic t_reset();
    check("R12 done after reset", 64'(done), 0);
    check("R1 rec_valid after reset", 64'(rec_valid), 0);
    check("R1 in_ready after reset", 64'(in_ready), 1);
  endtask

  task automatic t_good();
    build_good(8'd1);
    stall_mode = 1'b1; viol = 0;
    send(wp);
    check("R12 done", 64'(done), 1);
    check("R3 id_ok", 64'(id_ok), 1);
    check("R4 data_ok", 64'(data_ok), 1);
    check("R2 uid", uid, UID);
    check("R2 vendor", 64'(vendor_id), 64'h3A5C);
    check("R2 model", 64'(model_id), 64'hB217);
    check("R6 rev_warn low", 64'(rev_warn), 0);
    check("R5 size_err low with masked length", 64'(size_err), 0);
    check("R8 overrun low", 64'(overrun_err), 0);
    check("R9 port_len low", 64'(port_len_err), 0);
    settle();
    chk_recs("R7 good", 4, 32'h05C38201);
    check("R1 no accept while stalled", 64'(viol), 0);
    stall_mode = 1'b0;
  endtask

  task automatic t_data_bad();
    build_good(8'd3);
    img[9] ^= 8'h01;
    send(wp);
    check("R4 data_ok low", 64'(data_ok), 0);
    check("R3 id_ok kept", 64'(id_ok), 1);
    check("R6 rev_warn", 64'(rev_warn), 1);
    settle();
    chk_recs("R4 walk continues", 4, 32'h05C38201);
  endtask

  task automatic t_id_bad();
    build_good(8'd2);
    img[0] ^= 8'h80;
    send(wp);
    check("R3 id_ok low", 64'(id_ok), 0);
    check("R6 rev 2 no warn", 64'(rev_warn), 0);
    settle();
    check("R3 no records", 64'(rec_cnt), 0);
  endtask

  task automatic t_small();
    begin_img();
    finish_img(5, 8'd0);
    send(18);
    check("R5 size_err", 64'(size_err), 1);
    check("R10 not truncated", 64'(trunc_err), 0);
    settle();
    check("R5 no records", 64'(rec_cnt), 0);
  endtask

  task automatic t_ovr(input int kind);
    begin_img();
    ent(4, 8'h01);
    if (kind == 0) begin img[26] = 8'h00; wp = 30; end
    else if (kind == 1) begin img[26] = 8'd10; img[27] = 8'h02; wp = 30; end
    else begin img[26] = 8'd2; wp = 27; end
    finish_img(wp - 13, 8'd0);
    send(wp);
    check("R8 overrun", 64'(overrun_err), 1);
    check("R9 no port err", 64'(port_len_err), 0);
    settle();
    chk_recs("R8 records before overrun", 1, 32'h01);
  endtask

  task automatic t_port_len();
    begin_img();
    ent(4, 8'h01); ent(6, 8'h81); ent(2, 8'h05);
    finish_img(wp - 13, 8'd0);
    send(wp);
    check("R9 port_len_err", 64'(port_len_err), 1);
    check("R9 no overrun", 64'(overrun_err), 0);
    settle();
    chk_recs("R9 stop after bad port", 1, 32'h01);
  endtask

  task automatic t_port_skip();
    begin_img();
    ent(4, 8'h84); ent(2, 8'h07);
    finish_img(wp - 13, 8'd0);
    send(wp);
    check("R9 skip no port err", 64'(port_len_err), 0);
    check("R9 skip no overrun", 64'(overrun_err), 0);
    settle();
    chk_recs("R9 skip", 1, 32'h07);
  endtask

  task automatic t_trunc();
    build_good(8'd1);
    send(wp - 3);
    check("R10 trunc_err", 64'(trunc_err), 1);
    check("R10 data_ok low", 64'(data_ok), 0);
    settle();
    chk_recs("R10 partial", 3, 32'h00C38201);
  endtask

  task automatic t_trailing();
    int n;
    build_good(8'd1);
    n = wp;
    img[n] = 8'h02; img[n+1] = 8'h06; img[n+2] = 8'h02; img[n+3] = 8'h07;
    img[n+4] = 8'h00;
    send(n + 5);
    check("R11 data_ok", 64'(data_ok), 1);
    check("R11 no trunc", 64'(trunc_err), 0);
    check("R11 no overrun", 64'(overrun_err), 0);
    settle();
    chk_recs("R11 trailing", 4, 32'h05C38201);
  endtask

  task automatic t_one_byte();
    img[0] = 8'h55;
    send(1);
    check("R12 done again", 64'(done), 1);
    check("R12 uid cleared", uid, 0);
    check("R12 id_ok cleared", 64'(id_ok), 0);
    check("R10 one byte truncated", 64'(trunc_err), 1);
    settle();
    check("R12 no records", 64'(rec_cnt), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #3;
    t_reset();
    t_good();
    t_data_bad();
    t_id_bad();
    t_small();
    t_ovr(0);
    t_ovr(1);
    t_ovr(2);
    t_port_len();
    t_port_skip();
    t_trunc();
    t_trailing();
    t_one_byte();
    summary();
  end
endmodule